// File: doc/BRIEF.md
# Three-Wire Serial Memory Link Master

This block drives a byte-oriented serial link to an external memory using one clock output and one bidirectional data line. Software first places an outbound byte in a holding register, then writes a command word holding a bit count, a direction flag, a release-after-write flag and a wait-for-ready flag. Writing the command word starts the transfer. The block then produces the requested number of clock pulses, shifting bits out most-significant first or capturing them into a receive register. A busy status stays high for the whole transfer, and a one-cycle completion pulse marks the end.

With both the release and wait-for-ready flags set on a write, the block lets go of the data line after the last bit and stays busy until the memory pulls the line high to signal that it is ready. The serial clock is derived from the system clock by a parameterized divider. Each completion pulse also sets a sticky flag, which software clears by pulsing a clear input.

Top module: `ser3_link_master`

## Requirements
- R1: A command write (`cmd_we_i`) accepted while idle starts a command, and `busy_o` is high from the next cycle until the command completes. Command word layout: count in bits [3:0], read in bit 4, release in bit 5, wait-for-ready in bit 6. A count above 8 behaves as 8.
- R2: `sclk_o` is low whenever the block is idle. A command with count N gives exactly N pulses, each DIV_HALF system cycles low followed by DIV_HALF cycles high.
- R3: A write drives `sdata_o` from bit 7 of the loaded byte downward, one bit per pulse. The first bit is present before the first rising edge, and `sdata_o` changes only at falling edges of `sclk_o`.
- R4: A read keeps `sdata_oe_o` low for the whole command and samples `sdata_i` at each rising edge. Captured bits shift in from bit 0, so after N pulses `rx_data_o` holds the N bits in its low positions, with the first bit most significant. The receive register is cleared when a command starts.
- R5: After a write with release clear, the line stays driven with the last bit sent. After a write with release set, or after any read, `sdata_oe_o` is low.
- R6: A command with count 0 gives no pulses and no completion pulse, and is busy for exactly one cycle. Afterwards `sdata_oe_o` equals (not read) and (not release), and a driven line shows bit 7 of the loaded byte.
- R7: A write with release and wait-for-ready both set and a nonzero count releases the line after its last bit. It then stays busy while `sdata_i` is low and completes on the first cycle `sdata_i` is high. Wait-for-ready has no effect on reads or when release is clear.
- R8: `done_o` is a single-cycle pulse in the first cycle `busy_o` is low after a nonzero-count command, and it occurs nowhere else.
- R9: `done_flag_o` becomes 1 the cycle after `done_o` and holds until a `flag_clr_i` pulse. If the clear arrives in the same cycle as `done_o`, the set wins.
- R10: A command write while `busy_o` is high is ignored. The running command finishes unchanged.
- R11: After reset, `sclk_o`, `sdata_oe_o`, `busy_o`, `done_o` and `done_flag_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_wdata_i | input | CNT_W+3 | Command word: count, read, release, wait-for-ready |
| tx_we_i | input | 1 | Outbound byte write strobe |
| tx_wdata_i | input | DATA_W | Outbound byte |
| flag_clr_i | input | 1 | Clears the sticky completion flag |
| sdata_i | input | 1 | Data line as seen at the pin |
| sclk_o | output | 1 | Serial clock, idles low |
| sdata_o | output | 1 | Data line output value |
| sdata_oe_o | output | 1 | Data line output enable |
| busy_o | output | 1 | Command in progress |
| rx_data_o | output | DATA_W | Received bits |
| done_o | output | 1 | Completion pulse |
| done_flag_o | output | 1 | Sticky completion flag |

## Verification
Two events can fall in the same cycle. One is the completion pulse meeting a clear of the sticky flag. The other is a new command write arriving while a transfer is still running, possibly on the edge where that transfer ends. For the first, the bench runs a wait-for-ready write, raises `sdata_i`, and drives `flag_clr_i` so that it is sampled on the same edge that carries `done_o`. It then expects the flag to read 1. For the second, it injects a command write right after the first rising clock pulse of a running transfer, and the transfer must still show its original pulse count, bits and line state. Random commands with mixed counts, directions and flags, including counts above 8, are checked against expected values the bench computes itself.

// File: rtl/ser3_pkg.sv
package ser3_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ZERO,
    ST_LOW,
    ST_HIGH,
    ST_WAIT
  } ser3_state_e;

  typedef struct packed {
    logic wfr;
    logic hiz;
    logic rd;
  } ser3_flags_t;
endpackage

// File: rtl/ser3_phase.sv
module ser3_phase #(
  parameter int DIV_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (DIV_HALF <= 1) begin : g_direct
      assign tick_o = run_i;
    end else begin : g_count
      localparam int PW = $clog2(DIV_HALF);
      logic [PW-1:0] cnt_q;
      assign tick_o = run_i && (cnt_q == PW'(DIV_HALF - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      cnt_q <= '0;
        else if (!run_i)  cnt_q <= '0;
        else if (tick_o)  cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
      end
      a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= PW'(DIV_HALF - 1));
    end
  endgenerate
endmodule

// File: rtl/ser3_shift.sv
module ser3_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              adv_i,
  input  logic              cap_i,
  input  logic              sdi_i,
  output logic              tx_bit_o,
  output logic [DATA_W-1:0] rx_o
);
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tx_q <= '0;
    else if (load_i) tx_q <= load_data_i;
    else if (adv_i)  tx_q <= {tx_q[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rx_q <= '0;
    else if (load_i) rx_q <= '0;
    else if (cap_i)  rx_q <= {rx_q[DATA_W-2:0], sdi_i};
  end

  assign tx_bit_o = tx_q[DATA_W-1];
  assign rx_o     = rx_q;

  a_r4_cap_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !load_i) |=> rx_q[0] == $past(sdi_i));
endmodule

// File: rtl/ser3_fsm.sv
module ser3_fsm
  import ser3_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  ser3_flags_t      flags_i,
  input  logic             tick_i,
  input  logic             sdi_i,
  output logic             load_o,
  output logic             adv_o,
  output logic             cap_o,
  output logic             run_o,
  output logic             oe_o,
  output logic             sclk_o,
  output logic             busy_o,
  output logic             done_o
);
  ser3_state_e      state_q;
  ser3_flags_t      flg_q;
  logic [CNT_W-1:0] bits_q;
  logic [CNT_W-1:0] eff_cnt;
  logic             oe_q;
  logic             done_q;
  logic             accept;
  logic             last_bit;

  assign eff_cnt  = (cnt_i > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : cnt_i;
  assign accept   = cmd_we_i && (state_q == ST_IDLE);
  assign last_bit = (bits_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      flg_q   <= '0;
      bits_q  <= '0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          flg_q  <= flags_i;
          bits_q <= eff_cnt;
          if (eff_cnt == '0) begin
            state_q <= ST_ZERO;
            oe_q    <= !flags_i.rd && !flags_i.hiz;
          end else begin
            state_q <= ST_LOW;
            oe_q    <= !flags_i.rd;
          end
        end
        ST_ZERO: state_q <= ST_IDLE;
        ST_LOW:  if (tick_i) state_q <= ST_HIGH;
        ST_HIGH: if (tick_i) begin
          if (last_bit) begin
            oe_q <= !(flg_q.rd || flg_q.hiz);
            if (flg_q.wfr && flg_q.hiz && !flg_q.rd) begin
              state_q <= ST_WAIT;
            end else begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end
          end else begin
            bits_q  <= bits_q - 1'b1;
            state_q <= ST_LOW;
          end
        end
        ST_WAIT: if (sdi_i) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o = accept;
  assign cap_o  = (state_q == ST_LOW) && tick_i && flg_q.rd;
  assign adv_o  = (state_q == ST_HIGH) && tick_i && !last_bit && !flg_q.rd;
  assign run_o  = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign sclk_o = (state_q == ST_HIGH);
  assign busy_o = (state_q != ST_IDLE);
  assign oe_o   = oe_q;
  assign done_o = done_q;

  a_r10_ignore_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_we_i) |=> $stable(flg_q));
  a_r4_read_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && flg_q.rd) |-> !oe_q);
  a_r7_wait_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> !oe_q);
  a_r6_zero_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ZERO) |=> (state_q == ST_IDLE) && !done_q);
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/ser3_link_master.sv
module ser3_link_master
  import ser3_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_HALF = 2,
  localparam int CNT_W   = $clog2(DATA_W + 1),
  localparam int CMD_W   = CNT_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_wdata_i,
  input  logic              tx_we_i,
  input  logic [DATA_W-1:0] tx_wdata_i,
  input  logic              flag_clr_i,
  input  logic              sdata_i,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              done_o,
  output logic              done_flag_o
);
  logic [DATA_W-1:0] tx_hold_q;
  logic              flag_q;
  logic              tick, run, load, adv, cap;
  ser3_flags_t       flags;

  assign flags = ser3_flags_t'(cmd_wdata_i[CNT_W +: 3]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tx_hold_q <= '0;
    else if (tx_we_i) tx_hold_q <= tx_wdata_i;
  end

  ser3_phase #(.DIV_HALF(DIV_HALF)) u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  ser3_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_we_i(cmd_we_i),
    .cnt_i   (cmd_wdata_i[CNT_W-1:0]),
    .flags_i (flags),
    .tick_i  (tick),
    .sdi_i   (sdata_i),
    .load_o  (load),
    .adv_o   (adv),
    .cap_o   (cap),
    .run_o   (run),
    .oe_o    (sdata_oe_o),
    .sclk_o  (sclk_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  ser3_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_data_i(tx_hold_q),
    .adv_i      (adv),
    .cap_i      (cap),
    .sdi_i      (sdata_i),
    .tx_bit_o   (sdata_o),
    .rx_o       (rx_data_o)
  );

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (done_o)     flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end
  assign done_flag_o = flag_q;

  a_r2_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);
  a_r3_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));
  a_r8_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r9_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_flag_o);
endmodule

// File: tb/tb_ser3_link_master.sv
module tb_ser3_link_master;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [6:0] cmd_wdata = '0;
  logic       tx_we = 1'b0;
  logic [7:0] tx_wdata = '0;
  logic       flag_clr = 1'b0;
  logic       sdata_i = 1'b0;
  logic       sclk, sdata_o, sdata_oe, busy, done, done_flag;
  logic [7:0] rx_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  ser3_link_master #(.DATA_W(8), .DIV_HALF(2)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cmd_we_i   (cmd_we),
    .cmd_wdata_i(cmd_wdata),
    .tx_we_i    (tx_we),
    .tx_wdata_i (tx_wdata),
    .flag_clr_i (flag_clr),
    .sdata_i    (sdata_i),
    .sclk_o     (sclk),
    .sdata_o    (sdata_o),
    .sdata_oe_o (sdata_oe),
    .busy_o     (busy),
    .rx_data_o  (rx_data),
    .done_o     (done),
    .done_flag_o(done_flag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int eff_of(input int cnt);
    return (cnt > 8) ? 8 : cnt;
  endfunction

  function automatic logic [7:0] exp_rx(input logic [7:0] pat, input int eff);
    return (eff == 0) ? 8'h00 : 8'(pat >> (8 - eff));
  endfunction

  task automatic run_cmd(input int cnt, input bit rd, input bit hiz, input bit wfr,
                         input logic [7:0] txv, input logic [7:0] pat,
                         input bit inject, input int wdelay, input bit collide);
    int  eff = eff_of(cnt);
    int  pulses = 0, irqs = 0, bad_bits = 0, cyc = 0, wcnt = 0;
    bit  prev_sclk = 1'b0, irq_end = 1'b0, injected = 1'b0, drop_we = 1'b0;
    bit  wait_oe_bad = 1'b0, waiting;
    bit  wmode = wfr && hiz && !rd && (eff != 0);
    bit  exp_oe = !rd && !hiz;
    @(negedge clk);
    tx_we = 1'b1; tx_wdata = txv;
    @(negedge clk);
    tx_we = 1'b0; sdata_i = 1'b0;
    cmd_we = 1'b1; cmd_wdata = {wfr, hiz, rd, 4'(cnt)};
    @(negedge clk);
    cmd_we = 1'b0;
    check(busy == 1'b1, "R1", "busy after start", busy, 1);
    while (1) begin
      if (sclk && !prev_sclk) begin
        pulses++;
        if (pulses > 8) bad_bits++;
        else if (!rd) begin
          if (!sdata_oe || sdata_o !== txv[8-pulses]) bad_bits++;
        end else if (sdata_oe) bad_bits++;
      end
      if (done) irqs++;
      if (drop_we) begin cmd_we = 1'b0; drop_we = 1'b0; end
      if (!busy) begin irq_end = done; break; end
      if (inject && !injected && pulses == 1) begin
        cmd_we = 1'b1; cmd_wdata = 7'b0011000; injected = 1'b1; drop_we = 1'b1;
      end
      if (rd && !sclk && pulses < eff) sdata_i = pat[7-pulses];
      waiting = wmode && pulses == eff && !sclk;
      if (waiting) begin
        if (sdata_oe) wait_oe_bad = 1'b1;
        wcnt++;
        if (wcnt > wdelay) sdata_i = 1'b1;
      end
      prev_sclk = sclk;
      cyc++;
      if (cyc > 4000) begin
        check(1'b0, "R1", "command never completed", cyc, 0);
        break;
      end
      @(negedge clk);
    end
    cmd_we = 1'b0;
    if (collide && irq_end) begin
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      check(done_flag == 1'b1, "R9", "set wins over clear", done_flag, 1);
    end
    sdata_i = 1'b0;
    check(pulses == eff, (eff == 0) ? "R6" : "R2", "pulse count", pulses, eff);
    if (inject) check(pulses == eff && bad_bits == 0, "R10", "busy write ignored", pulses, eff);
    if (!rd) check(bad_bits == 0, "R3", "outbound bit errors", bad_bits, 0);
    else     check(bad_bits == 0, "R4", "read drove line", bad_bits, 0);
    check(irqs == ((eff != 0) ? 1 : 0), (eff == 0) ? "R6" : "R8", "done pulses", irqs, (eff != 0));
    check(irq_end == (eff != 0), "R8", "done at busy fall", irq_end, (eff != 0));
    if (rd && eff != 0) check(rx_data == exp_rx(pat, eff), "R4", "rx data", rx_data, exp_rx(pat, eff));
    check(sdata_oe == exp_oe, (eff == 0) ? "R6" : "R5", "final oe", sdata_oe, exp_oe);
    if (exp_oe) begin
      logic expb = (eff == 0) ? txv[7] : txv[8-eff];
      check(sdata_o == expb, (eff == 0) ? "R6" : "R5", "held bit", sdata_o, expb);
    end
    if (wmode) begin
      check(!wait_oe_bad, "R7", "line released in wait", wait_oe_bad, 0);
      check(wcnt > wdelay, "R7", "busy held until ready", wcnt, wdelay + 1);
    end
    @(negedge clk);
    if (eff != 0) begin
      check(done_flag == 1'b1, "R9", "sticky flag set", done_flag, 1);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      @(negedge clk);
      check(done_flag == 1'b0, "R9", "sticky flag cleared", done_flag, 0);
    end else begin
      check(done_flag == 1'b0, "R6", "no flag on zero count", done_flag, 0);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd7741);
    repeat (3) @(negedge clk);
    check(!sclk && !sdata_oe && !busy && !done && !done_flag, "R11", "reset outputs",
          {sclk, sdata_oe, busy, done, done_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!sclk && !busy, "R11", "idle after reset", {sclk, busy}, 0);

    run_cmd(8, 0, 0, 0, 8'hA5, 8'h00, 0, 0, 0);
    run_cmd(6, 0, 1, 0, 8'h3C, 8'h00, 0, 0, 0);
    run_cmd(8, 1, 0, 0, 8'hFF, 8'h96, 0, 0, 0);
    run_cmd(5, 1, 1, 1, 8'h00, 8'hD3, 0, 0, 0);
    run_cmd(0, 0, 0, 0, 8'h80, 8'h00, 0, 0, 0);
    run_cmd(0, 0, 1, 0, 8'h7F, 8'h00, 0, 0, 0);
    run_cmd(0, 1, 0, 0, 8'h80, 8'h00, 0, 0, 0);
    run_cmd(12, 0, 0, 0, 8'h5A, 8'h00, 0, 0, 0);
    run_cmd(1, 0, 0, 0, 8'h80, 8'h00, 0, 0, 0);
    run_cmd(6, 0, 1, 1, 8'hC9, 8'h00, 0, 5, 0);
    run_cmd(8, 0, 0, 1, 8'h81, 8'h00, 0, 0, 0);
    run_cmd(4, 0, 1, 1, 8'hE1, 8'h00, 0, 3, 1);
    run_cmd(7, 0, 0, 0, 8'h4B, 8'h00, 1, 0, 0);
    run_cmd(8, 1, 0, 0, 8'h00, 8'h2E, 1, 0, 0);

    for (int i = 0; i < 40; i++) begin
      run_cmd($urandom_range(0, 10), 1'($urandom), 1'($urandom), 1'($urandom),
              8'($urandom), 8'($urandom), 1'($urandom), $urandom_range(0, 6), 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule